// File: doc/BRIEF.md
# GPI Status Slot Capture with Local Read Bypass

This block sits on the receive side of a serial audio-codec link controller. A deserializer upstream hands it one complete input frame at a time: a 16-bit tag word, twelve 20-bit slots, the index of the codec that sent the frame, and a one-cycle frame-done strobe. The block picks out the slot that carries the codec's general-purpose input (GPI) pin states. It keeps the upper 16 bits of that slot in a shadow register, one shadow per codec. When the slot's change bit is set and the global interrupt enable is on, it latches a sticky interrupt.

Host register reads come in through a small read port. A read of a codec's GPI status address is answered on the next cycle from that codec's shadow, and nothing is sent over the link. Any other address is passed to the link command path as a one-cycle request. The block then waits for the link's response and returns that data.

The read path is a five-state machine:
- `RD_IDLE` accepts a request. A status address moves it to `RD_LOCAL`; any other address moves it to `RD_FWD_REQ`.
- `RD_LOCAL` returns the shadow data and goes back to `RD_IDLE`.
- `RD_FWD_REQ` issues the link request and moves to `RD_FWD_WAIT`.
- `RD_FWD_WAIT` holds until a link response arrives, then moves to `RD_FWD_DONE`.
- `RD_FWD_DONE` returns the response data and goes back to `RD_IDLE`.

Top module: `gpi_status_capture`

## Requirements
- R1: On a cycle with `frame_done_i` high, `frame_tag_i[15]` (frame valid) high and `frame_tag_i[3]` (GPI slot valid) high, the shadow of codec `frame_codec_i` takes bits [19:4] of slot 12. Slot 12 sits at `frame_slots_i[239:220]`, and slot k sits at bits `[(k-1)*20 +: 20]`. The shadows of the other codecs are not changed.
- R2: A frame with `frame_done_i` low, with tag bit 15 low, or with tag bit 3 low leaves every shadow unchanged.
- R3: The contents of slots 1 to 11, including the reserved slots 7 to 11, have no effect on any shadow or on the interrupt.
- R4: A captured frame whose slot 12 bit 0 (`frame_slots_i[220]`) is 1 sets `gpi_irq_o` on the following cycle only if `irq_en_i` is high in the capture cycle. With `irq_en_i` low, the interrupt is not set.
- R5: `gpi_irq_o` stays high until a cycle with `irq_clr_i` high clears it. When a set and a clear arrive in the same cycle, the set wins.
- R6: A read request accepted in `RD_IDLE` with address 8'h54 (codec 0) or 8'hD4 (codec 1) is answered on the next cycle:
  - `rd_valid_o` is high for one cycle, and `rd_data_o` carries that codec's current shadow.
  - `link_req_o` stays low.
- R7: A read request with any other address:
  - pulses `link_req_o` for one cycle on the next cycle, with `link_addr_o` equal to the requested address;
  - after `link_rsp_valid_i`, drives `rd_valid_o` high for one cycle with the `link_rsp_data_i` value sampled in the response cycle.
- R8: While `rd_busy_o` is high, new read requests are ignored: no link request is issued and no extra `rd_valid_o` is produced.
- R9: After reset, all shadows read 0, `gpi_irq_o` is 0, and the read machine is idle (`rd_busy_o`, `rd_valid_o` and `link_req_o` are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done_i | input | 1 | One-cycle strobe: a full input frame is present |
| frame_codec_i | input | 1 | Index of the codec that sent the frame |
| frame_tag_i | input | 16 | Input tag word: bit 15 is frame valid, bits 14..3 are slot 1..12 valid |
| frame_slots_i | input | 240 | Slots 1..12, slot k at bits [(k-1)*20 +: 20] |
| irq_en_i | input | 1 | Global GPI interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the sticky interrupt |
| gpi_irq_o | output | 1 | Sticky GPI-change interrupt |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | 8 | Host read register address |
| rd_valid_o | output | 1 | Read data valid (one cycle) |
| rd_data_o | output | 16 | Read data |
| rd_busy_o | output | 1 | Read machine not idle |
| link_req_o | output | 1 | One-cycle request to send a register read over the link |
| link_addr_o | output | 8 | Address for the link read |
| link_rsp_valid_i | input | 1 | Link read response valid |
| link_rsp_data_i | input | 16 | Link read response data |

## Verification
The bench uses the default parameters: two codecs, 20-bit slots, twelve slots, and the status offset at 8'h54 with a codec stride of 8'h80. With two codecs, the bench can show that a frame from one codec leaves the other codec's shadow unchanged. It also exercises both local addresses, 8'h54 and 8'hD4, alongside near-miss addresses such as 8'h55 that must go to the link. Because the slot 12 valid flag lands on tag bit 3, the bench can clear that single bit, and separately the frame-valid bit, to show that such frames are dropped even when slot 12 carries new data.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_LOCAL,
        RD_FWD_REQ,
        RD_FWD_WAIT,
        RD_FWD_DONE
    } rd_state_e;

endpackage

// File: rtl/gpi_frame_decode.sv
module gpi_frame_decode #(
    parameter int NUM_SLOTS = 12,
    parameter int SLOT_W    = 20,
    parameter int TAG_W     = 16,
    parameter int GPI_SLOT  = 12,
    parameter int GPI_W     = 16
) (
    input  logic                        frame_done_i,
    input  logic [TAG_W-1:0]            frame_tag_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] frame_slots_i,
    output logic                        cap_o,
    output logic [GPI_W-1:0]            status_o,
    output logic                        chg_o
);
    localparam int SLOT_LSB  = (GPI_SLOT - 1) * SLOT_W;
    localparam int FV_BIT    = TAG_W - 1;
    localparam int SV_BIT    = TAG_W - 1 - GPI_SLOT;

    logic [SLOT_W-1:0] gpi_slot;

    assign gpi_slot = frame_slots_i[SLOT_LSB +: SLOT_W];

    always_comb begin
        cap_o    = frame_done_i & frame_tag_i[FV_BIT] & frame_tag_i[SV_BIT];
        status_o = gpi_slot[SLOT_W-1 -: GPI_W];
        chg_o    = gpi_slot[0];
    end

endmodule

// File: rtl/gpi_shadow_bank.sv
module gpi_shadow_bank #(
    parameter int NUM_CODECS = 2,
    parameter int GPI_W      = 16,
    parameter int CODEC_W    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_i,
    input  logic [CODEC_W-1:0]          codec_i,
    input  logic [GPI_W-1:0]            status_i,
    output logic [NUM_CODECS*GPI_W-1:0] shadow_o
);
    for (genvar c = 0; c < NUM_CODECS; c++) begin : g_codec
        logic [GPI_W-1:0] shadow_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (cap_i && (codec_i == CODEC_W'(c))) begin
                shadow_q <= status_i;
            end
        end

        assign shadow_o[c*GPI_W +: GPI_W] = shadow_q;
    end

endmodule

// File: rtl/gpi_irq_sticky.sv
module gpi_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    input  logic chg_i,
    input  logic irq_en_i,
    input  logic irq_clr_i,
    output logic irq_o
);
    logic irq_q;
    logic set_w;

    assign set_w = cap_i & chg_i & irq_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (set_w) begin
            irq_q <= 1'b1;
        end else if (irq_clr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpi_read_fsm.sv
module gpi_read_fsm
    import gpi_pkg::*;
#(
    parameter int NUM_CODECS   = 2,
    parameter int GPI_W        = 16,
    parameter int ADDR_W       = 8,
    parameter int CODEC_W      = 1,
    parameter int GPI_OFFSET   = 'h54,
    parameter int CODEC_STRIDE = 'h80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_req_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    input  logic [NUM_CODECS*GPI_W-1:0] shadow_i,
    input  logic                        link_rsp_valid_i,
    input  logic [GPI_W-1:0]            link_rsp_data_i,
    output logic                        rd_valid_o,
    output logic [GPI_W-1:0]            rd_data_o,
    output logic                        rd_busy_o,
    output logic                        link_req_o,
    output logic [ADDR_W-1:0]           link_addr_o
);
    rd_state_e         state_q, state_d;
    logic              local_hit;
    logic [CODEC_W-1:0] hit_idx;
    logic [CODEC_W-1:0] sel_q;
    logic [ADDR_W-1:0] laddr_q;
    logic [GPI_W-1:0]  rsp_q;

    always_comb begin
        local_hit = 1'b0;
        hit_idx   = '0;
        for (int c = 0; c < NUM_CODECS; c++) begin
            if (rd_addr_i == ADDR_W'(GPI_OFFSET + c * CODEC_STRIDE)) begin
                local_hit = 1'b1;
                hit_idx   = CODEC_W'(c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (rd_req_i) begin
                    state_d = local_hit ? RD_LOCAL : RD_FWD_REQ;
                end
            end
            RD_LOCAL:    state_d = RD_IDLE;
            RD_FWD_REQ:  state_d = RD_FWD_WAIT;
            RD_FWD_WAIT: begin
                if (link_rsp_valid_i) begin
                    state_d = RD_FWD_DONE;
                end
            end
            RD_FWD_DONE: state_d = RD_IDLE;
            default:     state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            laddr_q <= '0;
            rsp_q   <= '0;
        end else begin
            if (state_q == RD_IDLE && rd_req_i) begin
                if (local_hit) begin
                    sel_q <= hit_idx;
                end else begin
                    laddr_q <= rd_addr_i;
                end
            end
            if (state_q == RD_FWD_WAIT && link_rsp_valid_i) begin
                rsp_q <= link_rsp_data_i;
            end
        end
    end

    always_comb begin
        rd_valid_o  = 1'b0;
        rd_data_o   = '0;
        link_req_o  = 1'b0;
        rd_busy_o   = (state_q != RD_IDLE);
        link_addr_o = laddr_q;
        unique case (state_q)
            RD_IDLE:     ;
            RD_LOCAL: begin
                rd_valid_o = 1'b1;
                rd_data_o  = shadow_i[sel_q*GPI_W +: GPI_W];
            end
            RD_FWD_REQ:  link_req_o = 1'b1;
            RD_FWD_WAIT: ;
            RD_FWD_DONE: begin
                rd_valid_o = 1'b1;
                rd_data_o  = rsp_q;
            end
            default:     ;
        endcase
    end

endmodule

// File: rtl/gpi_status_capture.sv
module gpi_status_capture #(
    parameter int NUM_CODECS   = 2,
    parameter int NUM_SLOTS    = 12,
    parameter int SLOT_W       = 20,
    parameter int TAG_W        = 16,
    parameter int GPI_SLOT     = 12,
    parameter int GPI_W        = 16,
    parameter int ADDR_W       = 8,
    parameter int GPI_OFFSET   = 'h54,
    parameter int CODEC_STRIDE = 'h80,
    localparam int CODEC_W     = (NUM_CODECS > 1) ? $clog2(NUM_CODECS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_done_i,
    input  logic [CODEC_W-1:0]          frame_codec_i,
    input  logic [TAG_W-1:0]            frame_tag_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] frame_slots_i,
    input  logic                        irq_en_i,
    input  logic                        irq_clr_i,
    output logic                        gpi_irq_o,
    input  logic                        rd_req_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output logic                        rd_valid_o,
    output logic [GPI_W-1:0]            rd_data_o,
    output logic                        rd_busy_o,
    output logic                        link_req_o,
    output logic [ADDR_W-1:0]           link_addr_o,
    input  logic                        link_rsp_valid_i,
    input  logic [GPI_W-1:0]            link_rsp_data_i
);
    logic                        cap_w;
    logic                        chg_w;
    logic [GPI_W-1:0]            status_w;
    logic [NUM_CODECS*GPI_W-1:0] shadow_w;

    gpi_frame_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W),
        .GPI_SLOT  (GPI_SLOT),
        .GPI_W     (GPI_W)
    ) decode_i (
        .frame_done_i  (frame_done_i),
        .frame_tag_i   (frame_tag_i),
        .frame_slots_i (frame_slots_i),
        .cap_o         (cap_w),
        .status_o      (status_w),
        .chg_o         (chg_w)
    );

    gpi_shadow_bank #(
        .NUM_CODECS (NUM_CODECS),
        .GPI_W      (GPI_W),
        .CODEC_W    (CODEC_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap_w),
        .codec_i  (frame_codec_i),
        .status_i (status_w),
        .shadow_o (shadow_w)
    );

    gpi_irq_sticky irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap_w),
        .chg_i     (chg_w),
        .irq_en_i  (irq_en_i),
        .irq_clr_i (irq_clr_i),
        .irq_o     (gpi_irq_o)
    );

    gpi_read_fsm #(
        .NUM_CODECS   (NUM_CODECS),
        .GPI_W        (GPI_W),
        .ADDR_W       (ADDR_W),
        .CODEC_W      (CODEC_W),
        .GPI_OFFSET   (GPI_OFFSET),
        .CODEC_STRIDE (CODEC_STRIDE)
    ) rd_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .rd_req_i         (rd_req_i),
        .rd_addr_i        (rd_addr_i),
        .shadow_i         (shadow_w),
        .link_rsp_valid_i (link_rsp_valid_i),
        .link_rsp_data_i  (link_rsp_data_i),
        .rd_valid_o       (rd_valid_o),
        .rd_data_o        (rd_data_o),
        .rd_busy_o        (rd_busy_o),
        .link_req_o       (link_req_o),
        .link_addr_o      (link_addr_o)
    );

endmodule

// File: rtl/gpi_status_capture_chk.sv
module gpi_status_capture_chk #(
    parameter int NUM_CODECS = 2,
    parameter int GPI_W      = 16,
    parameter int ADDR_W     = 8,
    parameter int GPI_OFFSET = 'h54
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cap_w,
    input logic                        chg_w,
    input logic                        irq_en_i,
    input logic                        irq_clr_i,
    input logic                        gpi_irq_o,
    input logic [NUM_CODECS*GPI_W-1:0] shadow_w,
    input logic                        rd_req_i,
    input logic [ADDR_W-1:0]           rd_addr_i,
    input logic                        rd_busy_o,
    input logic                        rd_valid_o,
    input logic                        link_req_o
);
    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_w |=> $stable(shadow_w));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gpi_irq_o) |-> $past(cap_w && chg_w && irq_en_i));

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gpi_irq_o && !irq_clr_i |=> gpi_irq_o);

    assert_local_no_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i && !rd_busy_o && (rd_addr_i == ADDR_W'(GPI_OFFSET))
        |=> rd_valid_o && !link_req_o);

    assert_link_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_req_o |=> !link_req_o);

    assert_busy_no_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy_o |=> !link_req_o);

endmodule

bind gpi_status_capture gpi_status_capture_chk #(
    .NUM_CODECS (NUM_CODECS),
    .GPI_W      (GPI_W),
    .ADDR_W     (ADDR_W),
    .GPI_OFFSET (GPI_OFFSET)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_w      (cap_w),
    .chg_w      (chg_w),
    .irq_en_i   (irq_en_i),
    .irq_clr_i  (irq_clr_i),
    .gpi_irq_o  (gpi_irq_o),
    .shadow_w   (shadow_w),
    .rd_req_i   (rd_req_i),
    .rd_addr_i  (rd_addr_i),
    .rd_busy_o  (rd_busy_o),
    .rd_valid_o (rd_valid_o),
    .link_req_o (link_req_o)
);

// File: tb/gpi_status_capture_tb_top.sv
module gpi_status_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_done_i = 1'b0;
    logic [0:0]   frame_codec_i = '0;
    logic [15:0]  frame_tag_i = '0;
    logic [239:0] frame_slots_i = '0;
    logic         irq_en_i = 1'b0;
    logic         irq_clr_i = 1'b0;
    logic         gpi_irq_o;
    logic         rd_req_i = 1'b0;
    logic [7:0]   rd_addr_i = '0;
    logic         rd_valid_o;
    logic [15:0]  rd_data_o;
    logic         rd_busy_o;
    logic         link_req_o;
    logic [7:0]   link_addr_o;
    logic         link_rsp_valid_i = 1'b0;
    logic [15:0]  link_rsp_data_i = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpi_status_capture dut_i (
        .clk (clk), .rst_n (rst_n),
        .frame_done_i (frame_done_i), .frame_codec_i (frame_codec_i),
        .frame_tag_i (frame_tag_i), .frame_slots_i (frame_slots_i),
        .irq_en_i (irq_en_i), .irq_clr_i (irq_clr_i), .gpi_irq_o (gpi_irq_o),
        .rd_req_i (rd_req_i), .rd_addr_i (rd_addr_i),
        .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o), .rd_busy_o (rd_busy_o),
        .link_req_o (link_req_o), .link_addr_o (link_addr_o),
        .link_rsp_valid_i (link_rsp_valid_i), .link_rsp_data_i (link_rsp_data_i)
    );

    // Behavioural reference model
    logic [15:0] m_sh [2];
    bit          m_irq;
    int          m_rs;     // 0 idle, 1 local, 2 fwd req, 3 wait, 4 done
    int          m_sel;
    logic [7:0]  m_laddr;
    logic [15:0] m_rdat;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh[0] = '0; m_sh[1] = '0; m_irq = 0; m_rs = 0; m_sel = 0;
            m_laddr = '0; m_rdat = '0;
        end else begin
            bit take;
            take = frame_done_i && frame_tag_i[15] && frame_tag_i[3];
            if (take && frame_slots_i[220] && irq_en_i) m_irq = 1;
            else if (irq_clr_i) m_irq = 0;
            case (m_rs)
                0: if (rd_req_i) begin
                       if (rd_addr_i == 8'h54) begin m_rs = 1; m_sel = 0; end
                       else if (rd_addr_i == 8'hD4) begin m_rs = 1; m_sel = 1; end
                       else begin m_rs = 2; m_laddr = rd_addr_i; end
                   end
                1: m_rs = 0;
                2: m_rs = 3;
                3: if (link_rsp_valid_i) begin m_rs = 4; m_rdat = link_rsp_data_i; end
                default: m_rs = 0;
            endcase
            if (take) m_sh[frame_codec_i] = frame_slots_i[239:224];
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] ed;
            ed = (m_rs == 1) ? m_sh[m_sel] : (m_rs == 4) ? m_rdat : 16'h0;
            chk("R5", "irq", 32'(gpi_irq_o), 32'(m_irq));
            chk("R6", "rd_valid", 32'(rd_valid_o), 32'(m_rs == 1 || m_rs == 4));
            chk("R1", "rd_data", 32'(rd_data_o), 32'(ed));
            chk("R8", "busy", 32'(rd_busy_o), 32'(m_rs != 0));
            chk("R7", "link_req", 32'(link_req_o), 32'(m_rs == 2));
            chk("R7", "link_addr", 32'(link_addr_o), 32'(m_laddr));
        end
    end

    function automatic logic [239:0] mk_slots(logic [19:0] s12, logic [19:0] fill);
        logic [239:0] v;
        for (int k = 0; k < 11; k++) v[k*20 +: 20] = fill ^ 20'(k * 20'h01111);
        v[239:220] = s12;
        return v;
    endfunction

    task automatic send_frame(bit done_b, bit codec, logic [15:0] tag,
                              logic [19:0] s12, logic [19:0] fill);
        @(posedge clk); #1;
        frame_done_i = done_b; frame_codec_i = codec; frame_tag_i = tag;
        frame_slots_i = mk_slots(s12, fill);
        @(posedge clk); #1;
        frame_done_i = 0; frame_tag_i = '0; frame_slots_i = '0;
    endtask

    task automatic local_read(logic [7:0] a, logic [15:0] exp, string req);
        @(posedge clk); #1; rd_req_i = 1; rd_addr_i = a;
        @(posedge clk); #1; rd_req_i = 0;
        chk(req, "local valid", 32'(rd_valid_o), 32'd1);
        chk(req, "local data", 32'(rd_data_o), 32'(exp));
        chk("R6", "no link", 32'(link_req_o), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset irq", 32'(gpi_irq_o), 0);
        chk("R9", "reset busy", 32'(rd_busy_o), 0);
        chk("R9", "reset link", 32'(link_req_o), 0);
        rst_n = 1;
        local_read(8'h54, 16'h0, "R9");
        local_read(8'hD4, 16'h0, "R9");

        // R1 capture per codec
        send_frame(1, 0, 16'h8008, {16'h1234, 4'h0}, 20'h0);
        local_read(8'h54, 16'h1234, "R1");
        local_read(8'hD4, 16'h0, "R1");
        // R3 garbage in slots 1..11 including reserved 7..11
        send_frame(1, 1, 16'hFFF8, {16'hA5C3, 4'h6}, 20'hFFFFF);
        local_read(8'hD4, 16'hA5C3, "R3");
        local_read(8'h54, 16'h1234, "R1");

        // R2 dropped frames
        send_frame(0, 0, 16'h8008, {16'hDEAD, 4'h1}, 20'h0);
        send_frame(1, 0, 16'h0008, {16'hDEAD, 4'h1}, 20'h0);
        send_frame(1, 0, 16'hFFF0, {16'hDEAD, 4'h1}, 20'h0);
        local_read(8'h54, 16'h1234, "R2");
        chk("R2", "no irq from dropped frames", 32'(gpi_irq_o), 0);

        // R4 enable gating
        irq_en_i = 0;
        send_frame(1, 0, 16'h8008, {16'h0F0F, 4'h1}, 20'h0);
        chk("R4", "irq disabled", 32'(gpi_irq_o), 0);
        irq_en_i = 1;
        send_frame(1, 0, 16'h8008, {16'h0F0E, 4'h0}, 20'h0);
        chk("R4", "no change bit", 32'(gpi_irq_o), 0);
        send_frame(1, 1, 16'h8008, {16'h7777, 4'h1}, 20'h0);
        chk("R4", "irq set", 32'(gpi_irq_o), 1);
        // R5 sticky and clear
        repeat (5) @(posedge clk);
        #1 chk("R5", "irq held", 32'(gpi_irq_o), 1);
        irq_clr_i = 1; @(posedge clk); #1 irq_clr_i = 0;
        chk("R5", "irq cleared", 32'(gpi_irq_o), 0);
        // simultaneous set and clear
        irq_clr_i = 1;
        send_frame(1, 0, 16'h8008, {16'h0001, 4'h1}, 20'h0);
        irq_clr_i = 0;
        chk("R5", "set wins", 32'(gpi_irq_o), 1);
        irq_clr_i = 1; @(posedge clk); #1 irq_clr_i = 0;
        irq_en_i = 0;
        local_read(8'h54, 16'h0001, "R1");

        // R7 forwarded read, with R8 requests while busy
        foreach (rd_addr_i[i]) begin end
        for (int n = 0; n < 2; n++) begin
            logic [7:0] a;
            logic [15:0] d;
            a = (n == 0) ? 8'h30 : 8'h55;
            d = (n == 0) ? 16'hBEEF : 16'h4242;
            @(posedge clk); #1; rd_req_i = 1; rd_addr_i = a;
            @(posedge clk); #1; rd_addr_i = 8'h54;   // still requesting: ignored (R8)
            chk("R7", "link req", 32'(link_req_o), 1);
            chk("R7", "link addr", 32'(link_addr_o), 32'(a));
            repeat (3) begin
                @(posedge clk); #1;
                chk("R8", "no extra link req", 32'(link_req_o), 0);
                chk("R8", "no valid while waiting", 32'(rd_valid_o), 0);
            end
            rd_req_i = 0;
            link_rsp_valid_i = 1; link_rsp_data_i = d;
            @(posedge clk); #1; link_rsp_valid_i = 0; link_rsp_data_i = '0;
            chk("R7", "fwd valid", 32'(rd_valid_o), 1);
            chk("R7", "fwd data", 32'(rd_data_o), 32'(d));
            @(posedge clk); #1;
            chk("R8", "single valid", 32'(rd_valid_o), 0);
        end

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule